// File: doc/BRIEF.md
# Module Stop Clock Gate Array

This block holds one stop bit for each peripheral module and turns it into a registered clock-enable for that module. A set stop bit holds the module's clock off. A clear bit lets the clock run. Software changes one module at a time by read-modify-write over a simple register bus. It reads a word, changes one bit and writes the word back. The bus is `BUS_W` bits wide (8, 16 or 32). The module bits are spread across as many words as needed. Module 0 sits at bit 0 of word 0.

A separate read-only status bank reports whether each module's clock is stopped. The status bank uses the same bit layout as the stop bank.

- **Stopping:** when a module is stopped, its status bit sets one cycle later, with no wait.
- **Waking:** when a module is released, its status bit stays set until the module has acknowledged. The acknowledge is modelled by a per-module latency input of 0 to 15 cycles.
- **Polling:** software polls the status bit and gives up after a bounded number of reads.

Top module: `modstop_gate`

## Requirements
- R1: While reset is low, every stop bit and every status bit read as 1 and every `clk_en` output is 0. Reset is synchronous and active low.
- R2: Writing 1 to a module's stop bit on clock edge E leaves `clk_en` for that module at its old value after E. The output drops to 0 after edge E+1.
- R3: Writing 0 to a module's stop bit on edge E raises that module's `clk_en` after edge E+1, one register stage after the stop register.
- R4: Address map and field positions:
  - NW = ceil(NUM_MOD/BUS_W).
  - Stop word k is at address k. Status word k is at address NW+k.
  - Module m is bit m mod BUS_W of word m div BUS_W in both banks.
  - BUS_W is 8, 16 or 32.
- R5: When a module with latency d is released on edge E, its status bit stays 1 until edge E+1+d and reads 0 after it. With continuous reads starting at edge E+1, the first read that returns 0 is the one issued on edge E+d+2.
- R6: Setting a stop bit on edge E sets that module's status bit on edge E+1, whatever its latency. A module with `clk_en` at 0 always shows status 1.
- R7: A write changes only the modules of the addressed stop word. Writes to status addresses or to unmapped addresses change no stop bit and no output.
- R8: A read issued on edge E returns its data on `bus_rdata` after E. Bits above NUM_MOD-1 read 0, and unmapped addresses read 0.
- R9: Stopping a module again while its wake-up is still pending keeps its status at 1. The next release waits the full latency again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| ack_delay | input | NUM_MOD*4 | Per-module acknowledge latency, 4 bits per module, module 0 lowest |
| clk_en | output | NUM_MOD | Registered clock enable per module, 1 = clock runs |

## Verification
Most faults in this block appear within one or two cycles at the ports. A stop register that loses or corrupts a bit shows on `clk_en` one cycle after the write, and in the readback of the stop word. A status tracker with a wrong count moves the first zero-reading poll away from latency plus two cycles after the write. A tracker that fails to restart on a re-stop shortens the next wake-up. A decode fault shows up as a wrong word on readback, or as a change in `clk_en` after a write to a status or unmapped address.

// File: rtl/modstop_pkg.sv
// Package: shared helpers for the module stop clock gate array.
// Assumes callers pass positive widths.
package modstop_pkg;

    // Width of the per-module acknowledge latency field.
    localparam int unsigned LAT_W = 4;

    // Which bank a bus address falls into.
    typedef enum logic [1:0] {
        BANK_STOP = 2'd0,
        BANK_STAT = 2'd1,
        BANK_NONE = 2'd2
    } bank_e;

    // Number of bus words needed to hold n bits at width w.
    function automatic int unsigned words_for(int unsigned n, int unsigned w);
        return (n + w - 1) / w;
    endfunction

endpackage

// File: rtl/modstop_chan.sv
// Module: one gate channel. It registers the clock enable from the stop bit
// and tracks the status bit. Status sets one cycle after stop. Status clears
// only after the stop bit has been low for the acknowledge latency.
// Assumes the stop input comes from a register in the same clock domain.
module modstop_chan
    import modstop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic [LAT_W-1:0] delay,
    output logic             en,
    output logic             stat
);

    logic             en_q;
    logic             stat_q;
    logic [LAT_W-1:0] cnt_q;

    // Registered enable so the gate only changes on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= ~stop;
    end

    // Status tracker: set at once on stop, clear after the latency on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b1;
            cnt_q  <= '0;
        end else if (stop) begin
            stat_q <= 1'b1;
            cnt_q  <= '0;
        end else if (stat_q) begin
            if (cnt_q >= delay) stat_q <= 1'b0;
            else                cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign en   = en_q;
    assign stat = stat_q;

    AST_EN_TRACKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        en_q == !$past(stop)); // R3
    AST_STOP_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> stat_q); // R6
    AST_GATED_IS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> stat_q); // R6
    AST_CLEAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q |-> en_q); // R5

endmodule

// File: rtl/modstop_regs.sv
// Module: register bank. It decodes the word address, keeps the stop bits and
// returns stop or status words one cycle after a read strobe.
// Assumes 2*NW words fit in ADDR_W bits.
module modstop_regs
    import modstop_pkg::*;
#(
    parameter int unsigned NUM_MOD = 12,
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [NUM_MOD-1:0] stat_vec,
    output logic [NUM_MOD-1:0] stop_vec,
    output logic [BUS_W-1:0]   rdata
);

    localparam int unsigned NW  = words_for(NUM_MOD, BUS_W);
    localparam int unsigned PAD = NW * BUS_W;

    if (2 * NW > (1 << ADDR_W)) begin : g_addr_check
        $error("ADDR_W too small for the register map");
    end

    logic [NUM_MOD-1:0] stop_q;
    logic [BUS_W-1:0]   rdata_q;
    logic [PAD-1:0]     stop_pad;
    logic [PAD-1:0]     stat_pad;
    logic [BUS_W-1:0]   rd_next;
    bank_e              bank;

    // Classify the address into a bank.
    always_comb begin
        if (addr < ADDR_W'(NW))          bank = BANK_STOP;
        else if (addr < ADDR_W'(2 * NW)) bank = BANK_STAT;
        else                             bank = BANK_NONE;
    end

    // Stop register: a write touches only the bits of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= '1;
        end else if (wr && bank == BANK_STOP) begin
            for (int i = 0; i < NUM_MOD; i++) begin
                if (addr == ADDR_W'(i / BUS_W)) stop_q[i] <= wdata[i % BUS_W];
            end
        end
    end

    // Zero-padded copies of both banks so every word is BUS_W wide.
    always_comb begin
        stop_pad = '0;
        stat_pad = '0;
        stop_pad[NUM_MOD-1:0] = stop_q;
        stat_pad[NUM_MOD-1:0] = stat_vec;
    end

    // Read mux: select the addressed word of the addressed bank.
    always_comb begin
        rd_next = '0;
        for (int w = 0; w < NW; w++) begin
            if (addr == ADDR_W'(w))      rd_next = stop_pad[w*BUS_W +: BUS_W];
            if (addr == ADDR_W'(NW + w)) rd_next = stat_pad[w*BUS_W +: BUS_W];
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_next;
    end

    assign stop_vec = stop_q;
    assign rdata    = rdata_q;

    AST_FOREIGN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr >= ADDR_W'(NW)) |=> $stable(stop_q)); // R7
    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr >= ADDR_W'(2 * NW)) |=> rdata_q == '0); // R8
    AST_NO_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(stop_q)); // R7

endmodule

// File: rtl/modstop_gate.sv
// Module: top of the module stop clock gate array. It joins the register
// bank to one gate channel per module.
// Assumes BUS_W is 8, 16 or 32 and each latency field is 4 bits wide.
module modstop_gate
    import modstop_pkg::*;
#(
    parameter int unsigned NUM_MOD = 12,
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    input  logic [NUM_MOD*LAT_W-1:0] ack_delay,
    output logic [NUM_MOD-1:0]       clk_en
);

    if (BUS_W != 8 && BUS_W != 16 && BUS_W != 32) begin : g_width_check
        $error("BUS_W must be 8, 16 or 32");
    end

    logic [NUM_MOD-1:0] stop_vec;
    logic [NUM_MOD-1:0] stat_vec;

    modstop_regs #(
        .NUM_MOD (NUM_MOD),
        .BUS_W   (BUS_W),
        .ADDR_W  (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .stat_vec (stat_vec),
        .stop_vec (stop_vec),
        .rdata    (bus_rdata)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_chan
        modstop_chan i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .stop  (stop_vec[m]),
            .delay (ack_delay[m*LAT_W +: LAT_W]),
            .en    (clk_en[m]),
            .stat  (stat_vec[m])
        );
    end

    AST_RESET_GATED: assert property (@(posedge clk)
        !rst_n |=> clk_en == '0); // R1

endmodule

// File: tb/test_modstop_gate.sv
module test_modstop_gate;
    localparam int NUM_MOD = 12;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic [NUM_MOD*4-1:0] ack_delay;
    logic [NUM_MOD-1:0] clk_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    modstop_gate #(.NUM_MOD(NUM_MOD), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_modstop_gate (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_delay(ack_delay), .clk_en(clk_en)
    );

    // Module m has acknowledge latency m.
    initial begin
        for (int m = 0; m < NUM_MOD; m++) ack_delay[m*4 +: 4] = 4'(m);
    end

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // One write; returns at the negedge right after the write edge E.
    task automatic do_write(int a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = BUS_W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(int a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    // Call right after do_write: continuous reads, find first read edge E+k with bit 0.
    task automatic poll_clear(int a, int b, int exp_k, string req);
        int found = 0;
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (found == 0 && bus_rdata[b] == 1'b0) found = k;
        end
        bus_rd = 1'b0;
        check(req, found, exp_k);
    endtask

    task automatic t_reset();
        int d;
        check("R1 clk_en", int'(clk_en), 0);
        do_read(0, d); check("R1 stop w0", d, 'hFF);
        do_read(1, d); check("R8 stop w1 pad", d, 'h0F);
        do_read(2, d); check("R1 stat w0", d, 'hFF);
        do_read(3, d); check("R1 stat w1", d, 'h0F);
    endtask

    task automatic t_wake_mod3();
        do_write(0, 'hF7);
        check("R3 en not yet", int'(clk_en), 0);
        @(negedge clk);
        check("R3 en after E+1", int'(clk_en), 'h008);
        do_write(0, 'hF7);
        poll_clear(2, 3, 2, "R5 d=3 already clear");
    endtask

    task automatic t_wake_latency();
        do_write(0, 'hFF);
        do_write(0, 'hF7);
        poll_clear(2, 3, 5, "R5 mod3 latency");
        do_write(0, 'hF6);
        poll_clear(2, 0, 2, "R5 mod0 latency 0");
        do_write(1, 'h07);
        poll_clear(3, 3, 13, "R4 mod11 word1 latency");
        check("R4 clk_en", int'(clk_en), 'h809);
    endtask

    task automatic t_stop();
        do_write(0, 'hFE);
        check("R2 en holds after E", int'(clk_en), 'h809);
        bus_rd = 1'b1; bus_addr = 2;
        @(negedge clk);
        check("R2 en drops after E+1", int'(clk_en), 'h801);
        check("R6 stat before", int'(bus_rdata[3]), 0);
        @(negedge clk);
        check("R6 stat set next cycle", int'(bus_rdata[3]), 1);
        bus_rd = 1'b0;
    endtask

    task automatic t_ignored();
        int d;
        do_write(2, 'h00);
        do_write(3, 'h00);
        do_write(5, 'h00);
        @(negedge clk);
        check("R7 clk_en unchanged", int'(clk_en), 'h801);
        do_read(0, d); check("R7 stop w0 kept", d, 'hFE);
        do_read(1, d); check("R7 stop w1 kept", d, 'h07);
        do_read(6, d); check("R8 unmapped read", d, 0);
        do_write(1, 'hF7);
        do_read(1, d); check("R8 pad bits zero", d, 'h07);
        do_read(0, d); check("R7 other word kept", d, 'hFE);
    endtask

    task automatic t_restop();
        int d;
        do_write(1, 'h0F);
        do_write(1, 'h07);
        repeat (4) @(negedge clk);
        do_write(1, 'h0F);
        repeat (2) @(negedge clk);
        do_read(3, d); check("R9 stat held", (d >> 3) & 1, 1);
        do_write(1, 'h07);
        poll_clear(3, 3, 13, "R9 full latency again");
        check("R9 clk_en", int'(clk_en), 'h801);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 clk_en in reset", int'(clk_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wake_mod3();
        t_wake_latency();
        t_stop();
        t_ignored();
        t_restop();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule